// File: doc/BRIEF.md
# SPI Master Controller with Register Bus

This block is an SPI master that a processor drives through five 32-bit registers. Software writes outgoing words into a transmit FIFO. The shift engine sends each word on MOSI and, during the same word, collects a word from MISO into a receive FIFO. Software then pops received words by reading the receive data register. Three build parameters fix the word width (8, 16 or 32 bits), the FIFO depth and the serial clock rate; software cannot change any of them. Clock polarity, clock phase and bit order come from the control register, and these three fields give all four SPI modes in both bit orders.

Software usually sets a transmit-hold bit, fills the transmit FIFO and then clears the bit, so that a burst goes out back to back. The active-low slave-select register picks the target. In manual mode the select lines follow that register at all times. In automatic mode they follow it only while words are being shifted. Each FIFO has a clear bit in the control register that resets itself. Each FIFO has an overrun pulse that reports a dropped word. The interrupt logic is a separate block that consumes these pulses and the status bits.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset, the control register reads 0, the status register reads 0x05 (both FIFOs empty), the slave-select register reads all ones, `ss_n` is all ones, `sclk` is 0 and both overrun pulses are low.
- R2: Register word addresses on `reg_addr`: 0 control, 1 status, 2 transmit data (a write pushes `reg_wdata[WORD_W-1:0]`), 3 receive data, 4 slave select. Read data appears on `reg_rdata` one cycle after the request.
- R3: While control bit 8 (transmit hold) is 1, `sclk` does not toggle, even when the transmit FIFO holds words. Clearing the bit starts shifting from the oldest word.
- R4: Shifting starts only when control bit 1 (enable) and control bit 2 (master) are both 1.
- R5: Control bit 3 (CPOL) sets the idle level of `sclk`. With control bit 4 (CPHA) at 0, data is sampled on the first, third, ... edge of each word and changes on the others. With CPHA at 1, the roles swap. Each word takes 2×WORD_W edges, spaced HALF_DIV clock cycles apart.
- R6: Words are sent and received MSB first when control bit 9 is 0, and LSB first when it is 1.
- R7: Each word shifted out places one received word into the receive FIFO. A read of the receive data register returns the oldest received word and removes it. The read returns 0 when the FIFO is empty.
- R8: Writing 1 to control bit 5 empties the transmit FIFO, and writing 1 to control bit 6 empties the receive FIFO, in the write cycle. Both bits read back as 0.
- R9: A write to a full transmit FIFO is dropped and `tx_ovf` is high for one cycle. A received word that finds the receive FIFO full is dropped and `rx_ovf` is high for one cycle.
- R10: The slave-select register is active low, one bit per slave. When control bit 7 (manual select) is 1, `ss_n` follows the register at all times. When it is 0, `ss_n` follows the register while a burst is shifting, stays asserted between back-to-back words, and is all ones when idle.
- R11: Status bits: 0 receive empty, 1 receive full, 2 transmit empty, 3 transmit full, 4 mode fault (always 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slaves |
| miso | input | 1 | Serial data from the selected slave |
| ss_n | output | N_SS | Active-low slave selects |
| tx_ovf | output | 1 | Pulse: transmit word dropped |
| rx_ovf | output | 1 | Pulse: received word dropped |

## Verification
If a FIFO pointer is corrupted, the status register shows it at the next read. The word order on the serial line, or the data read back, is also wrong within the same burst. If the edge counter or phase logic is wrong, the bench slave model receives a misplaced or shifted word. That shows after one word time, 2×WORD_W×HALF_DIV+1 cycles. A wrong hold or enable gate shows as `sclk` activity during a window where none is allowed. A wrong select state is visible on `ss_n` in the middle of a burst and again right after it.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_TXD  = 3'd2;
  localparam logic [2:0] A_RXD  = 3'd3;
  localparam logic [2:0] A_SSEL = 3'd4;

  localparam int C_EN    = 1;
  localparam int C_MST   = 2;
  localparam int C_CPOL  = 3;
  localparam int C_CPHA  = 4;
  localparam int C_TXCLR = 5;
  localparam int C_RXCLR = 6;
  localparam int C_MANSS = 7;
  localparam int C_HOLD  = 8;
  localparam int C_LSB   = 9;
  // bits kept in the control register (clear bits are strobes)
  localparam logic [9:0] CTRL_KEEP = 10'b11_1001_1110;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb;
  } spi_mode_t;
endpackage

// File: rtl/spi_host_fifo.sv
module spi_host_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full,
  output logic         ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp_q, rp_q;
  logic         do_push, do_pop;

  assign empty   = (wp_q == rp_q);
  assign full    = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp_q[AW-1:0]];

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp_q[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q <= '0;
      rp_q <= '0;
      ovf  <= 1'b0;
    end else begin
      ovf <= push && full;
      if (clr) begin
        wp_q <= '0;
        rp_q <= '0;
      end else begin
        if (do_push) wp_q <= wp_q + 1'b1;
        if (do_pop)  rp_q <= rp_q + 1'b1;
      end
    end
  end

  // R8
  clr_empties_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> empty);

  // R9
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !clr) |=> (full && ovf));
endmodule

// File: rtl/spi_host_shift.sv
module spi_host_shift
  import spi_host_pkg::*;
#(
  parameter int W        = 8,
  parameter int HALF_DIV = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go_i,
  input  spi_mode_t    mode_i,
  input  logic         have_i,
  input  logic [W-1:0] word_i,
  input  logic         miso_i,
  output logic         take_o,
  output logic         done_o,
  output logic [W-1:0] rx_o,
  output logic         busy_o,
  output logic         sclk_o,
  output logic         mosi_o
);
  localparam int EW = $clog2(2 * W);
  localparam int BW = $clog2(W);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic          busy_q, sclk_q, mosi_q;
  logic [CW-1:0] cnt_q;
  logic [EW-1:0] ecnt_q;
  logic [W-1:0]  tx_q, rx_q, rx_nx;
  spi_mode_t     mode_l;
  logic          start, edge_now, lead, last, samp;
  logic [BW-1:0] bi, nb;

  function automatic logic [BW-1:0] bpos(input logic [BW-1:0] i, input logic lsb);
    return lsb ? i : (BW'(W - 1) - i);
  endfunction

  assign start    = go_i && have_i && !busy_q;
  assign edge_now = busy_q && (cnt_q == CW'(HALF_DIV - 1));
  assign bi       = ecnt_q[EW-1:1];
  assign nb       = bi + 1'b1;
  assign lead     = !ecnt_q[0];
  assign last     = (ecnt_q == EW'(2 * W - 1));
  assign samp     = mode_l.cpha ? !lead : lead;

  always_comb begin
    rx_nx = rx_q;
    if (samp) rx_nx[bpos(bi, mode_l.lsb)] = miso_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      ecnt_q <= '0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      mode_l <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      ecnt_q <= '0;
      tx_q   <= word_i;
      rx_q   <= '0;
      mode_l <= mode_i;
      sclk_q <= mode_i.cpol;
      if (!mode_i.cpha) mosi_q <= word_i[bpos('0, mode_i.lsb)];
    end else if (busy_q) begin
      if (edge_now) begin
        cnt_q  <= '0;
        ecnt_q <= ecnt_q + 1'b1;
        sclk_q <= !sclk_q;
        rx_q   <= rx_nx;
        if (mode_l.cpha && lead) mosi_q <= tx_q[bpos(bi, mode_l.lsb)];
        if (!mode_l.cpha && !lead && !last) mosi_q <= tx_q[bpos(nb, mode_l.lsb)];
        if (last) busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      sclk_q <= mode_i.cpol;
    end
  end

  assign take_o = start;
  assign done_o = edge_now && last;
  assign rx_o   = rx_nx;
  assign busy_o = busy_q;
  assign sclk_o = sclk_q;
  assign mosi_o = mosi_q;

  // R3
  hold_blocks_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !go_i) |=> !busy_q);

  // R5
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> (sclk_q == mode_l.cpol));
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int WORD_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int HALF_DIV   = 2,
  parameter int N_SS       = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_en,
  input  logic            reg_we,
  input  logic [2:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            sclk,
  output logic            mosi,
  input  logic            miso,
  output logic [N_SS-1:0] ss_n,
  output logic            tx_ovf,
  output logic            rx_ovf
);
  logic              wr, rd;
  logic [9:0]        ctrl_q;
  logic [N_SS-1:0]   ss_q, ss_n_q;
  logic              tx_push, tx_clr, rx_clr, rx_pop;
  logic [WORD_W-1:0] tx_head, rx_head, rx_word;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic              take, done, busy, go;
  spi_mode_t         mode;
  logic [31:0]       rd_mux;

  assign wr      = reg_en && reg_we;
  assign rd      = reg_en && !reg_we;
  assign tx_push = wr && (reg_addr == A_TXD);
  assign tx_clr  = wr && (reg_addr == A_CTRL) && reg_wdata[C_TXCLR];
  assign rx_clr  = wr && (reg_addr == A_CTRL) && reg_wdata[C_RXCLR];
  assign rx_pop  = rd && (reg_addr == A_RXD);
  assign go      = ctrl_q[C_EN] && ctrl_q[C_MST] && !ctrl_q[C_HOLD];
  assign mode    = '{cpol: ctrl_q[C_CPOL], cpha: ctrl_q[C_CPHA], lsb: ctrl_q[C_LSB]};

  spi_host_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .clr(tx_clr), .push(tx_push),
    .wdata(reg_wdata[WORD_W-1:0]), .pop(take), .rdata(tx_head),
    .empty(tx_empty), .full(tx_full), .ovf(tx_ovf));

  spi_host_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .clr(rx_clr), .push(done),
    .wdata(rx_word), .pop(rx_pop), .rdata(rx_head),
    .empty(rx_empty), .full(rx_full), .ovf(rx_ovf));

  spi_host_shift #(.W(WORD_W), .HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst(rst), .go_i(go), .mode_i(mode), .have_i(!tx_empty),
    .word_i(tx_head), .miso_i(miso), .take_o(take), .done_o(done),
    .rx_o(rx_word), .busy_o(busy), .sclk_o(sclk), .mosi_o(mosi));

  always_comb begin
    case (reg_addr)
      A_CTRL:  rd_mux = 32'(ctrl_q);
      A_STAT:  rd_mux = 32'({1'b0, tx_full, tx_empty, rx_full, rx_empty});
      A_RXD:   rd_mux = rx_empty ? 32'd0 : 32'(rx_head);
      A_SSEL:  rd_mux = 32'(ss_q);
      default: rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      ss_q      <= '1;
      ss_n_q    <= '1;
      reg_rdata <= '0;
    end else begin
      if (wr && reg_addr == A_CTRL) ctrl_q <= reg_wdata[9:0] & CTRL_KEEP;
      if (wr && reg_addr == A_SSEL) ss_q <= reg_wdata[N_SS-1:0];
      if (rd) reg_rdata <= rd_mux;
      if (ctrl_q[C_MANSS] || busy || take) ss_n_q <= ss_q;
      else                                 ss_n_q <= '1;
    end
  end

  assign ss_n = ss_n_q;

  // R10
  manual_ss_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[C_MANSS] && $past(ctrl_q[C_MANSS])) |-> (ss_n == $past(ss_q)));
endmodule

// File: tb/spi_host_ctrl_tb.sv
module spi_host_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 8;
  localparam int DEP = 16;
  localparam int HD  = 2;
  localparam int NS  = 4;
  localparam int WORD_CYC = 2 * W * HD + 1;

  localparam logic [31:0] EN = 32'h002, MST = 32'h004, CPOL = 32'h008, CPHA = 32'h010;
  localparam logic [31:0] TXC = 32'h020, RXC = 32'h040, MAN = 32'h080, HOLD = 32'h100, LSB = 32'h200;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_en = 1'b0, reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic sclk, mosi, miso, tx_ovf, rx_ovf;
  logic [NS-1:0] ss_n;

  int n_chk = 0, n_bad = 0;
  int n_txovf = 0, n_rxovf = 0;

  spi_host_ctrl #(.WORD_W(W), .FIFO_DEPTH(DEP), .HALF_DIV(HD), .N_SS(NS)) u_dut (
    .clk(clk), .rst(rst), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .ss_n(ss_n), .tx_ovf(tx_ovf), .rx_ovf(rx_ovf));

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [W-1:0] pat(int k);
    return W'(k * 29 + 75);
  endfunction

  // slave model
  bit s_cpha = 1'b0, s_lsb = 1'b0;
  int s_n = 0, s_done = 0, edges = 0;
  logic [W-1:0] s_out = pat(0), s_in = '0;
  logic [W-1:0] s_got [0:1023];

  always @(sclk) begin
    if (!rst) begin
      edges = edges + 1;
      s_n = s_n + 1;
      if (!s_cpha && (s_n % 2 == 1)) s_in[s_lsb ? (s_n - 1) / 2 : W - 1 - (s_n - 1) / 2] = mosi;
      if (s_cpha && (s_n % 2 == 0)) s_in[s_lsb ? s_n / 2 - 1 : W - s_n / 2] = mosi;
      if (s_n == 2 * W) begin
        s_got[s_done % 1024] = s_in;
        s_done = s_done + 1;
        s_out = pat(s_done);
        s_n = 0;
      end
    end
  end

  always_comb begin
    int idx;
    if (s_cpha) idx = (s_n > 0) ? (s_n - 1) / 2 : 0;
    else        idx = s_n / 2;
    miso = s_out[s_lsb ? idx : W - 1 - idx];
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (tx_ovf) n_txovf = n_txovf + 1;
      if (rx_ovf) n_rxovf = n_rxovf + 1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic set_ctrl(logic [31:0] v);
    wr(3'd0, v);
    s_cpha = v[4];
    s_lsb  = v[9];
    cyc(3);
    s_n = 0;
  endtask

  task automatic finish_up;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // preload under hold, release, then compare both directions
  task automatic run_burst(int n, logic [31:0] base, logic [NS-1:0] ssv);
    logic [W-1:0] exp_tx [0:15];
    logic [31:0] v;
    int e0, d0;
    wr(3'd4, 32'(ssv));
    set_ctrl(base | HOLD);
    e0 = edges; d0 = s_done;
    for (int i = 0; i < n; i++) begin
      exp_tx[i] = W'($urandom);
      wr(3'd2, 32'(exp_tx[i]));
    end
    cyc(30);
    chk("R3 no sclk edges while hold set", 32'(edges - e0), 32'd0);
    wr(3'd0, base);
    cyc(10);
    chk("R10 ss_n during burst", 32'(ss_n), 32'(ssv));
    cyc(n * WORD_CYC + 20);
    chk("R5 edge count per burst", 32'(edges - e0), 32'(2 * W * n));
    chk("R7 words seen by slave", 32'(s_done - d0), 32'(n));
    for (int i = 0; i < n; i++)
      chk("R6 word on mosi", 32'(s_got[(d0 + i) % 1024]), 32'(exp_tx[i]));
    for (int i = 0; i < n; i++) begin
      rd(3'd3, v);
      chk("R7 received word", v, 32'(pat(d0 + i)));
    end
    rd(3'd1, v);
    chk("R11 status after burst", v, 32'h05);
    chk("R5 sclk idle level", 32'(sclk), 32'(base[3]));
    chk("R10 ss_n after burst", 32'(ss_n), base[7] ? 32'(ssv) : 32'(4'hF));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [31:0] v;
    logic [W-1:0] ov [0:DEP-1];
    int e0, d0, t0, r0;
    void'($urandom(32'h5EED));
    cyc(4);
    rst = 1'b0;
    cyc(2);
    s_n = 0; edges = 0;

    // R1 reset state
    rd(3'd0, v); chk("R1 control reset", v, 32'h0);
    rd(3'd1, v); chk("R1 R11 status reset", v, 32'h05);
    rd(3'd4, v); chk("R1 select reg reset", v, 32'hF);
    chk("R1 ss_n reset", 32'(ss_n), 32'hF);
    chk("R1 sclk reset", 32'(sclk), 32'h0);
    rd(3'd3, v); chk("R7 R2 empty rx read", v, 32'h0);

    // directed manual select burst
    run_burst(3, EN | MST | MAN, 4'b1110);

    // R4 enable and master both required
    e0 = edges; d0 = s_done;
    wr(3'd0, MST);
    wr(3'd2, 32'h5A);
    cyc(60);
    chk("R4 no shifting without enable", 32'(edges - e0), 32'd0);
    wr(3'd0, EN);
    cyc(60);
    chk("R4 no shifting without master", 32'(edges - e0), 32'd0);
    wr(3'd0, EN | MST);
    cyc(WORD_CYC + 20);
    chk("R4 word sent once enabled", 32'(s_got[d0 % 1024]), 32'h5A);
    rd(3'd3, v); chk("R4 R7 reply word", v, 32'(pat(d0)));

    // R5 R6 R10 all modes, both bit orders, manual and automatic select
    for (int m = 0; m < 8; m++) begin
      logic [31:0] b;
      logic [NS-1:0] ssv;
      b = EN | MST;
      if (m[0]) b = b | CPOL;
      if (m[1]) b = b | CPHA;
      if (m[2]) b = b | LSB;
      if (m % 3 == 0) b = b | MAN;
      ssv = ~(NS'(1) << ($urandom % NS));
      run_burst(1 + int'($urandom % 5), b, ssv);
    end
    set_ctrl(EN | MST);

    // R8 transmit FIFO clear
    set_ctrl(EN | MST | HOLD);
    for (int i = 0; i < 4; i++) wr(3'd2, 32'(i + 1));
    rd(3'd1, v); chk("R8 tx holds words", v, 32'h01);
    wr(3'd0, EN | MST | HOLD | TXC);
    rd(3'd1, v); chk("R8 tx emptied by clear", v, 32'h05);
    rd(3'd0, v); chk("R8 clear bit reads 0", v, EN | MST | HOLD);
    e0 = edges;
    wr(3'd0, EN | MST);
    cyc(60);
    chk("R8 nothing shifted after clear", 32'(edges - e0), 32'd0);

    // R8 receive FIFO clear
    wr(3'd2, 32'h11);
    wr(3'd2, 32'h22);
    cyc(2 * WORD_CYC + 20);
    rd(3'd1, v); chk("R8 rx holds words", v, 32'h04);
    wr(3'd0, EN | MST | RXC);
    rd(3'd1, v); chk("R8 rx emptied by clear", v, 32'h05);

    // R9 transmit overrun
    set_ctrl(EN | MST | HOLD);
    t0 = n_txovf; r0 = n_rxovf; d0 = s_done;
    for (int i = 0; i < DEP; i++) begin
      ov[i] = W'($urandom);
      wr(3'd2, 32'(ov[i]));
    end
    rd(3'd1, v); chk("R9 R11 tx full status", v, 32'h09);
    chk("R9 no tx overrun yet", 32'(n_txovf - t0), 32'd0);
    wr(3'd2, 32'hEE);
    cyc(2);
    chk("R9 tx overrun pulse", 32'(n_txovf - t0), 32'd1);
    wr(3'd0, EN | MST);
    cyc(DEP * WORD_CYC + 20);
    chk("R9 dropped word not sent", 32'(s_done - d0), 32'(DEP));
    for (int i = 0; i < DEP; i++)
      chk("R9 kept tx word", 32'(s_got[(d0 + i) % 1024]), 32'(ov[i]));
    rd(3'd1, v); chk("R9 R11 rx full status", v, 32'h06);
    chk("R9 no rx overrun yet", 32'(n_rxovf - r0), 32'd0);

    // R9 receive overrun
    wr(3'd2, 32'h77);
    cyc(WORD_CYC + 10);
    chk("R9 rx overrun pulse", 32'(n_rxovf - r0), 32'd1);
    for (int i = 0; i < DEP; i++) begin
      rd(3'd3, v);
      chk("R9 rx keeps older words", v, 32'(pat(d0 + i)));
    end
    rd(3'd1, v); chk("R9 R11 status drained", v, 32'h05);

    finish_up();
  end
endmodule